// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block connects a processor bus to three 8-bit peripheral ports, called A, B and C. Port C is handled as two independent 4-bit halves. The processor side has active-low chip-select, read and write strobes, a 2-bit register address and split data-in and data-out buses. The data-out bus has an enable that marks when the block drives it. A single control register sets whether each port, and each half of port C, is an input or an output. The same address also accepts single-bit commands that set or clear one pin latch of port C.

Every port line has an output latch, and each port has an output-enable per line. A latch always takes the data written to it. It drives its pins only while its port or half is configured as output. Reading a port configured as input returns the live pin values, and port C input is never latched.

The ports are plain level signals with no flow control. A bus transfer is a strobe cycle, not a stream. A write takes effect once per strobe, on its first clock. A read is combinational and stays valid for as long as the read strobe is held.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset the control word reads back 0x9B. Every port output-enable is 0 (all ports are inputs), and every output latch is 0.
- R2: Nothing happens on the bus while cs_n is high: writes are ignored and bus_oe stays 0. bus_oe is 1 only while cs_n and rd_n are low and wr_n is high.
- R3: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. A read of 11 returns the control word currently held.
- R4: A write to address 11 with bit 7 set stores the whole word as the configuration. Bit 4 sets the port A direction, bit 3 the upper half of port C, bit 1 port B and bit 0 the lower half of port C. A value of 1 means input, and the output-enables of that group go to 0.
- R5: A configuration write (bit 7 = 1) clears every output latch of ports A, B and C to 0.
- R6: A write to address 11 with bit 7 clear leaves the control word unchanged. It writes bit 0 into the port C latch bit selected by bits 3..1 (000 = bit 0 up to 111 = bit 7) and leaves the other latch bits unchanged.
- R7: A data write to a port address always loads that port's latch, even when the port is an input. The latch value appears on the pins once the port is configured as output.
- R8: A read of a port returns the live pins for each port or port C half configured as input, and the latch value for each one configured as output.
- R9: A write acts once per strobe, on the first clock where cs_n and wr_n are both low. Changes on bus_din later in the same strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data to the processor |
| bus_oe | output | 1 | High while bus_dout is driven |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin drive enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pin drive enables, per half |

## Verification
The hardest case to reach from the ports is a held write strobe whose data changes partway through. Every normal write repeats the same value, so the single-capture rule is invisible. A directed step therefore holds the strobe for two clocks and changes bus_din between them. A bench reference model then follows a long random mix of configuration words, port C bit commands and data writes to ports in both directions, with random pin levels. This exercises the per-half merge on port C reads and writes to latches that are not driving their pins.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [DW-1:0] CTL_RESET = 8'h9B;

  typedef enum logic [AW-1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  // decoded direction of each group (1 = input)
  typedef struct packed {
    logic a_in;
    logic chi_in;
    logic b_in;
    logic clo_in;
  } dir_t;
endpackage

// File: rtl/ppio_bus_if.sv
module ppio_bus_if
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          wr_pulse,
  output logic          rd_en,
  output sel_e          sel
);
  logic wr_act, wr_act_q;

  assign wr_act = !cs_n && !wr_n;
  assign rd_en  = !cs_n && !rd_n && wr_n;
  assign sel    = sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  // one action per strobe: first clock only
  assign wr_pulse = wr_act && !wr_act_q;
endmodule

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg
  import ppio_pkg::*;
#(
  parameter int W  = DW,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_pulse,
  input  sel_e          sel,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  ctrl_q,
  output dir_t          dir,
  output logic          cfg_we,
  output logic          bsr_we,
  output logic [IW-1:0] bsr_idx,
  output logic          bsr_val
);
  logic ctl_hit;

  assign ctl_hit = wr_pulse && (sel == SEL_CTL);
  assign cfg_we  = ctl_hit && din[W-1];
  assign bsr_we  = ctl_hit && !din[W-1];
  assign bsr_idx = din[IW:1];
  assign bsr_val = din[0];

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= CTL_RESET;
    else if (cfg_we) ctrl_q <= din;
  end

  assign dir.a_in   = ctrl_q[4];
  assign dir.chi_in = ctrl_q[3];
  assign dir.b_in   = ctrl_q[1];
  assign dir.clo_in = ctrl_q[0];
endmodule

// File: rtl/ppio_port_latch.sv
module ppio_port_latch #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (we)    q <= wdata;
    else if (bit_we) q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int IW    = $clog2(DW);
  localparam int NIB   = DW / 2;
  localparam int NIW   = $clog2(NIB);

  logic          wr_pulse, rd_en, cfg_we, bsr_we, bsr_val;
  sel_e          sel;
  logic [DW-1:0] ctrl_q;
  dir_t          dir;
  logic [IW-1:0] bsr_idx;
  logic [DW-1:0] pc_rd;

  ppio_bus_if u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wr_pulse(wr_pulse), .rd_en(rd_en), .sel(sel)
  );

  ppio_ctrl_reg #(.W(DW)) u_ctl (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .sel(sel), .din(bus_din),
    .ctrl_q(ctrl_q), .dir(dir), .cfg_we(cfg_we), .bsr_we(bsr_we),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  ppio_port_latch #(.W(DW)) u_pa (
    .clk(clk), .rst(rst), .clr(cfg_we), .we(wr_pulse && sel == SEL_A),
    .wdata(bus_din), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );

  ppio_port_latch #(.W(DW)) u_pb (
    .clk(clk), .rst(rst), .clr(cfg_we), .we(wr_pulse && sel == SEL_B),
    .wdata(bus_din), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );

  // port C: two independently directed halves, h=0 lower, h=1 upper
  for (genvar h = 0; h < 2; h++) begin : g_pc
    logic            half_in;
    logic [NIB-1:0]  q;
    assign half_in = (h == 0) ? dir.clo_in : dir.chi_in;

    ppio_port_latch #(.W(NIB)) u_pc (
      .clk(clk), .rst(rst), .clr(cfg_we),
      .we(wr_pulse && sel == SEL_C),
      .wdata(bus_din[h*NIB +: NIB]),
      .bit_we(bsr_we && (bsr_idx[IW-1] == h[0])),
      .bit_idx(bsr_idx[NIW-1:0]),
      .bit_val(bsr_val),
      .q(q)
    );

    assign pc_out[h*NIB +: NIB] = q;
    assign pc_oe[h*NIB +: NIB]  = {NIB{!half_in}};
    assign pc_rd[h*NIB +: NIB]  = half_in ? pc_in[h*NIB +: NIB] : q;
  end

  assign pa_oe = {DW{!dir.a_in}};
  assign pb_oe = {DW{!dir.b_in}};

  always_comb begin
    bus_dout = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_A:   bus_dout = dir.a_in ? pa_in : pa_out;
        SEL_B:   bus_dout = dir.b_in ? pb_in : pb_out;
        SEL_C:   bus_dout = pc_rd;
        default: bus_dout = ctrl_q;
      endcase
    end
  end
  assign bus_oe = rd_en;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] bus_din,
  input logic       bus_oe,
  input logic       wr_pulse,
  input logic       cfg_we,
  input logic       bsr_we,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe
);
  logic strobe;
  assign strobe = !cs_n && !wr_n;

  assert_no_write_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !wr_pulse);

  assert_no_read_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !bus_oe);

  assert_cfg_dir_a_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> pa_oe == {8{!$past(bus_din[4])}});

  assert_cfg_clears_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  assert_bsr_keeps_dir_R6: assert property (@(posedge clk) disable iff (rst)
    bsr_we |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  assert_bsr_keeps_ab_R6: assert property (@(posedge clk) disable iff (rst)
    bsr_we |=> ($stable(pa_out) && $stable(pb_out)));

  assert_single_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe && $past(strobe)) |-> !wr_pulse);
endmodule

bind ppio_ctrl ppio_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
  .bus_din(bus_din), .bus_oe(bus_oe), .wr_pulse(wr_pulse), .cfg_we(cfg_we),
  .bsr_we(bsr_we), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] bus_din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] bus_dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic bus_oe;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_ctl = 8'h9B, m_a = '0, m_b = '0, m_c = '0;

  always #5 clk = ~clk;

  ppio_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_oe(input int g);
    case (g)
      0: return {8{!m_ctl[4]}};
      1: return {8{!m_ctl[1]}};
      default: return {{4{!m_ctl[3]}}, {4{!m_ctl[0]}}};
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl[4] ? pa_in : m_a;
      2'd1: return m_ctl[1] ? pb_in : m_b;
      2'd2: return {m_ctl[3] ? pc_in[7:4] : m_c[7:4], m_ctl[0] ? pc_in[3:0] : m_c[3:0]};
      default: return m_ctl;
    endcase
  endfunction

  task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: if (d[7]) begin m_ctl = d; m_a = '0; m_b = '0; m_c = '0; end
               else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; bus_din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [1:0] a, input string req);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1;
    chk(req, {7'b0, bus_oe}, 8'h01);
    chk(req, bus_dout, exp_rd(a));
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic chk_pins(input string req);
    #1;
    chk(req, pa_oe, exp_oe(0)); chk(req, pb_oe, exp_oe(1)); chk(req, pc_oe, exp_oe(2));
    chk(req, pa_out, m_a); chk(req, pb_out, m_b); chk(req, pc_out, m_c);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_pins("R1");
    bus_rd(2'd3, "R1");
    // R2 deselected write ignored, deselected read not driven
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; bus_din = 8'hA5;
    @(negedge clk); wr_n = 1;
    chk_pins("R2");
    @(negedge clk); rd_n = 0; addr = 2'd3; #1;
    chk("R2", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); rd_n = 1;
    // R7 write to input port loads latch, appears when output
    bus_wr(2'd0, 8'h3C);
    chk_pins("R7");
    pa_in = 8'hF0;
    bus_rd(2'd0, "R8");
    bus_wr(2'd3, 8'h80);          // all outputs, clears latches (R4, R5)
    chk_pins("R5");
    bus_rd(2'd3, "R3");
    bus_wr(2'd0, 8'h5A);
    bus_rd(2'd0, "R7");
    // R6 bit set/reset, bit 7 and bit 0 corners
    bus_wr(2'd3, 8'h0F);          // set bit 7
    bus_wr(2'd3, 8'h01);          // set bit 0
    chk_pins("R6");
    bus_wr(2'd3, 8'h0E);          // clear bit 7
    chk_pins("R6");
    bus_rd(2'd3, "R6");
    // R8 split halves: upper input, lower output
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'h6B);
    pc_in = 8'hD2;
    bus_rd(2'd2, "R8");
    chk_pins("R4");
    // R9 held strobe with changing data
    @(negedge clk); cs_n = 0; wr_n = 0; addr = 2'd1; bus_din = 8'h11;
    @(negedge clk); bus_din = 8'hEE;
    @(negedge clk); cs_n = 1; wr_n = 1;
    m_b = 8'h11;
    chk_pins("R9");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if ($urandom_range(0, 2) == 0) bus_rd(a, "R8");
      else begin
        if (a == 2'd3 && d[7] && $urandom_range(0, 3) != 0) d[7] = 1'b0;
        bus_wr(a, d);
        chk_pins(a == 2'd3 ? (d[7] ? "R4" : "R6") : "R7");
      end
    end
    bus_rd(2'd3, "R3");
    finish_run();
  end
endmodule